// File: doc/BRIEF.md
# Pipeline Hazard Stall and Forwarding Controller

This block is the data-hazard control for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). It reads the register identifiers, write enables and the load flag that the surrounding pipeline registers hold. From them it decides two things. The first is whether the instruction in decode must wait one cycle behind a load. The second is where each execute-stage ALU operand should come from.

The block also holds the architectural register file. The file has two read ports and one write port. A writeback in a cycle is visible to a decode read in that same cycle, so no bypass is needed from writeback into decode. When a load in execute writes a register that the decode instruction reads, the block holds the program counter and the fetch/decode register, and turns the next decode/execute slot into a bubble. The bubble moves on as a non-load, so the stall lasts one cycle. After that, the loaded value reaches the dependent instruction through the memory/writeback forward path.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with no write yet, every register reads as zero on both read ports.
- R2: Register 0 always reads zero. A writeback that targets register 0 leaves it at zero.
- R3: When writeback writes register N in a cycle, a read of N in that same cycle returns the written data, not the old contents.
- R4: A value written to register N (N not 0) reads back on either port in every later cycle until N is written again.
- R5: A stall is raised when the execute instruction is a load (`ex_load`=1) with a nonzero destination that equals `dec_rs1` or `dec_rs2`.
- R6: No stall is raised when the execute instruction is not a load, when the load's destination is register 0, or when the destination matches neither decode source.
- R7: `pc_hold`, `ifid_hold` and `idex_bubble` are always equal. All three are 1 exactly when R5 applies.
- R8: An operand select of 2'b10 (execute/memory ALU result) is given when `mem_wen`=1, `mem_rd` is nonzero and `mem_rd` equals that operand's execute-stage source register.
- R9: An operand select of 2'b01 (memory/writeback value) is given when `wb_wen`=1, `wb_rd` is nonzero, `wb_rd` equals the source, and R8 does not apply.
- R10: When both the execute/memory and memory/writeback destinations match a source, the select is 2'b10. The nearer producer wins.
- R11: The select is 2'b00 (register file) when neither later stage writes a matching nonzero register. A source of register 0 always gets 2'b00, and the code 2'b11 is never produced.
- R12: The two operand selects are decided independently, each from its own source register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| dec_rs1 | input | 5 | First source register of the decode instruction; register-file read port 1 address |
| dec_rs2 | input | 5 | Second source register of the decode instruction; read port 2 address |
| ex_rs1 | input | 5 | First source register of the execute instruction |
| ex_rs2 | input | 5 | Second source register of the execute instruction |
| ex_rd | input | 5 | Destination register of the execute instruction |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | 5 | Destination register held in execute/memory |
| mem_wen | input | 1 | Execute/memory instruction writes a register |
| wb_rd | input | 5 | Destination register held in memory/writeback |
| wb_wen | input | 1 | Memory/writeback instruction writes a register |
| wb_data | input | 32 | Data written back |
| rd_data1 | output | 32 | Read data for `dec_rs1` |
| rd_data2 | output | 32 | Read data for `dec_rs2` |
| pc_hold | output | 1 | Keep the program counter unchanged this cycle |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged this cycle |
| idex_bubble | output | 1 | Load a bubble into decode/execute this cycle |
| fwd_a | output | 2 | Operand A source: 00 register file, 10 execute/memory, 01 memory/writeback |
| fwd_b | output | 2 | Operand B source, same coding as `fwd_a` |

## Verification
The assertions assume that the pipeline inputs are stable between clock edges and already hold known values once reset is released. They also assume that a register write shows only as `wb_wen` with `wb_rd`/`wb_data` and is taken at the rising edge. The stimulus changes every input only on the falling edge. It draws register identifiers from a small range, so that matches between stages, register 0 and simultaneous matches in both later stages occur often. The directed part walks through the load-then-use sequence, the write-first case and the priority case, and a long random run then covers the other combinations.

// File: rtl/pipe_hazard_pkg.sv
package pipe_hazard_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_WB  = 2'b01,
    SRC_MEM = 2'b10
  } opnd_src_e;
endpackage

// File: rtl/phc_regfile.sv
module phc_regfile #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] rd1,
  output logic [DW-1:0] rd2
);
  logic [DW-1:0] regs [NREG];
  logic [NREG-1:0] wr_sel;

  always_comb begin
    wr_sel = '0;
    if (we && (wa != '0)) wr_sel[wa] = 1'b1;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign regs[i] = '0;
    end else begin : g_store
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         q <= '0;
        else if (wr_sel[i]) q <= wd;
      end
      assign regs[i] = q;
    end
  end

  // write-first: a same-cycle write overrides the stored word on the read ports
  always_comb begin
    rd1 = regs[ra1];
    rd2 = regs[ra2];
    if (we && (wa != '0) && (wa == ra1)) rd1 = wd;
    if (we && (wa != '0) && (wa == ra2)) rd2 = wd;
  end

  AST_RF_WRITE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (wa != '0)) |=> (regs[$past(wa)] == $past(wd)));            // R4
  AST_RF_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (ra1 == '0) |-> (rd1 == '0));                                        // R2
  AST_RF_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (wa != '0) && (wa == ra2)) |-> (rd2 == wd));                  // R3
endmodule

// File: rtl/phc_load_use.sv
module phc_load_use #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] dec_rs1,
  input  logic [AW-1:0] dec_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_load,
  output logic          stall
);
  logic hit1, hit2;

  always_comb begin
    hit1  = (ex_rd == dec_rs1);
    hit2  = (ex_rd == dec_rs2);
    stall = ex_load && (ex_rd != '0) && (hit1 || hit2);
  end

  AST_STALL_ONLY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> ex_load);                                                  // R6
  AST_STALL_NOT_R0: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rd == '0) |-> !stall);                                           // R6
endmodule

// File: rtl/phc_fwd_sel.sv
module phc_fwd_sel
  import pipe_hazard_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wen,
  output opnd_src_e     sel
);
  logic mem_hit, wb_hit;

  always_comb begin
    mem_hit = mem_wen && (mem_rd != '0) && (mem_rd == src);
    wb_hit  = wb_wen  && (wb_rd  != '0) && (wb_rd  == src);
    if (mem_hit)     sel = SRC_MEM;
    else if (wb_hit) sel = SRC_WB;
    else             sel = SRC_RF;
  end

  AST_FWD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));                                                      // R11
  AST_FWD_R0_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |-> (sel == SRC_RF));                                    // R11
  AST_FWD_MEM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wen && wb_wen && (mem_rd == wb_rd) && (mem_rd == src) && (src != '0))
      |-> (sel == SRC_MEM));                                             // R10
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import pipe_hazard_pkg::*;
#(
  parameter int NREG = 32,
  parameter int DW   = 32,
  localparam int AW  = $clog2(NREG),
  localparam int NOP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] dec_rs1,
  input  logic [AW-1:0] dec_rs2,
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wen,
  input  logic [DW-1:0] wb_data,
  output logic [DW-1:0] rd_data1,
  output logic [DW-1:0] rd_data2,
  output logic          pc_hold,
  output logic          ifid_hold,
  output logic          idex_bubble,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b
);
  logic            stall;
  logic [AW-1:0]   ex_src [NOP];
  opnd_src_e       op_sel [NOP];

  phc_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra1(dec_rs1), .ra2(dec_rs2),
    .we(wb_wen), .wa(wb_rd), .wd(wb_data),
    .rd1(rd_data1), .rd2(rd_data2)
  );

  phc_load_use #(.AW(AW)) u_lu (
    .clk(clk), .rst_n(rst_n),
    .dec_rs1(dec_rs1), .dec_rs2(dec_rs2),
    .ex_rd(ex_rd), .ex_load(ex_load),
    .stall(stall)
  );

  assign ex_src[0] = ex_rs1;
  assign ex_src[1] = ex_rs2;

  for (genvar k = 0; k < NOP; k++) begin : g_op
    phc_fwd_sel #(.AW(AW)) u_fs (
      .clk(clk), .rst_n(rst_n),
      .src(ex_src[k]),
      .mem_rd(mem_rd), .mem_wen(mem_wen),
      .wb_rd(wb_rd), .wb_wen(wb_wen),
      .sel(op_sel[k])
    );
  end

  always_comb begin
    pc_hold     = stall;
    ifid_hold   = stall;
    idex_bubble = stall;
    fwd_a       = op_sel[0];
    fwd_b       = op_sel[1];
  end

  AST_HOLDS_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_hold == ifid_hold) && (ifid_hold == idex_bubble));               // R7
  AST_LOAD_USE_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_load && (ex_rd != '0) && (ex_rd == dec_rs2)) |-> pc_hold);       // R5
endmodule

// File: tb/pipe_hazard_ctrl_bench.sv
`timescale 1ns/1ps
module pipe_hazard_ctrl_bench;
  localparam int NREG = 32;
  localparam int DW   = 32;
  localparam int AW   = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] dec_rs1, dec_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic ex_load, mem_wen, wb_wen;
  logic [DW-1:0] wb_data;
  logic [DW-1:0] rd_data1, rd_data2;
  logic pc_hold, ifid_hold, idex_bubble;
  logic [1:0] fwd_a, fwd_b;

  int checks = 0;
  int failures = 0;
  logic [DW-1:0] mdl [NREG];

  always #2 clk = ~clk;

  pipe_hazard_ctrl #(.NREG(NREG), .DW(DW)) u_pipe_hazard_ctrl (
    .clk(clk), .rst_n(rst_n),
    .dec_rs1(dec_rs1), .dec_rs2(dec_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
    .ex_rd(ex_rd), .ex_load(ex_load), .mem_rd(mem_rd), .mem_wen(mem_wen),
    .wb_rd(wb_rd), .wb_wen(wb_wen), .wb_data(wb_data),
    .rd_data1(rd_data1), .rd_data2(rd_data2),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
    .fwd_a(fwd_a), .fwd_b(fwd_b)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
    if (a == 0) return '0;
    if (wb_wen && wb_rd == a) return wb_data;
    return mdl[a];
  endfunction

  function automatic logic [1:0] exp_sel(input logic [AW-1:0] s);
    if (s != 0 && mem_wen && mem_rd == s) return 2'b10;
    if (s != 0 && wb_wen && wb_rd == s) return 2'b01;
    return 2'b00;
  endfunction

  // compare every output with the model, then let one clock edge pass
  task automatic cyc(input string tag);
    logic st;
    #1;
    st = ex_load && (ex_rd != 0) && (ex_rd == dec_rs1 || ex_rd == dec_rs2);
    chk({tag, " R3/R4 rd_data1"}, rd_data1, exp_read(dec_rs1));
    chk({tag, " R3/R4 rd_data2"}, rd_data2, exp_read(dec_rs2));
    chk({tag, " R5/R6 pc_hold"}, {31'b0, pc_hold}, {31'b0, st});
    chk({tag, " R7 ifid_hold"}, {31'b0, ifid_hold}, {31'b0, st});
    chk({tag, " R7 idex_bubble"}, {31'b0, idex_bubble}, {31'b0, st});
    chk({tag, " R8-R11 fwd_a"}, {30'b0, fwd_a}, {30'b0, exp_sel(ex_rs1)});
    chk({tag, " R12 fwd_b"}, {30'b0, fwd_b}, {30'b0, exp_sel(ex_rs2)});
    @(posedge clk);
    if (rst_n && wb_wen && wb_rd != 0) mdl[wb_rd] = wb_data;
    @(negedge clk);
  endtask

  task automatic idle();
    dec_rs1 = 0; dec_rs2 = 0; ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0; ex_load = 0;
    mem_rd = 0; mem_wen = 0; wb_rd = 0; wb_wen = 0; wb_data = '0;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) mdl[i] = '0;
    rst_n = 1'b0;
    idle();
    repeat (2) @(negedge clk);
    // R1: reset state, reads of several registers return zero
    dec_rs1 = 5'd7; dec_rs2 = 5'd31;
    cyc("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    dec_rs1 = 5'd3; dec_rs2 = 5'd12;
    cyc("R1 after reset");

    // R3: write-first same-cycle read; R4: later read
    wb_wen = 1; wb_rd = 5'd5; wb_data = 32'hA5A5_0001; dec_rs1 = 5'd5; dec_rs2 = 5'd5;
    cyc("R3 same-cycle");
    wb_wen = 0; cyc("R4 later read");
    chk("R4 explicit", rd_data1, 32'hA5A5_0001);
    // R2: write to register 0 discarded
    wb_wen = 1; wb_rd = 0; wb_data = 32'hDEAD_BEEF; dec_rs1 = 0; dec_rs2 = 0;
    cyc("R2 write r0");
    wb_wen = 0; #1 chk("R2 r0 stays zero", rd_data2, 32'h0); cyc("R2 r0 after");

    // load-use: load r6 in execute, decode reads r6 -> one stall (R5, R7)
    ex_load = 1; ex_rd = 5'd6; dec_rs1 = 5'd1; dec_rs2 = 5'd6;
    #1 chk("R5 load-use stall", {31'b0, pc_hold}, 32'd1); cyc("R5 stall cycle");
    // bubble now in execute, load in memory: no stall
    ex_load = 0; ex_rd = 0; mem_rd = 5'd6; mem_wen = 1;
    #1 chk("R6 bubble in ex no stall", {31'b0, idex_bubble}, 32'd0); cyc("R6 after bubble");
    // dependent now in execute, load in writeback: forward 01 (R9)
    mem_wen = 0; mem_rd = 0; wb_wen = 1; wb_rd = 5'd6; wb_data = 32'h0000_0066;
    ex_rs1 = 5'd1; ex_rs2 = 5'd6;
    #1 chk("R9 wb forward", {30'b0, fwd_b}, 32'd1); cyc("R9 wb fwd");
    // R6: load to r0 and non-matching load
    idle(); ex_load = 1; ex_rd = 0; cyc("R6 load r0");
    ex_rd = 5'd9; dec_rs1 = 5'd8; dec_rs2 = 5'd10; cyc("R6 no match");
    // R10: both stages match
    idle(); mem_wen = 1; mem_rd = 5'd4; wb_wen = 1; wb_rd = 5'd4; wb_data = 32'h44;
    ex_rs1 = 5'd4; ex_rs2 = 5'd2;
    #1 chk("R10 mem over wb", {30'b0, fwd_a}, 32'd2); chk("R12 other operand rf", {30'b0, fwd_b}, 32'd0);
    cyc("R10 priority");
    // R11: source r0 with matching r0 destinations, and write enable low
    idle(); mem_wen = 1; wb_wen = 1; ex_rs1 = 0; ex_rs2 = 0; cyc("R11 r0 src");
    idle(); mem_rd = 5'd3; wb_rd = 5'd3; ex_rs1 = 5'd3; cyc("R11 wen low");
    // R8 on operand b only
    idle(); mem_wen = 1; mem_rd = 5'd11; ex_rs2 = 5'd11; cyc("R8 mem fwd b");

    // random traffic over a small register range
    for (int n = 0; n < 4000; n++) begin
      dec_rs1 = AW'($urandom_range(0, 3)); dec_rs2 = AW'($urandom_range(0, 3));
      ex_rs1  = AW'($urandom_range(0, 3)); ex_rs2  = AW'($urandom_range(0, 3));
      ex_rd   = AW'($urandom_range(0, 3)); ex_load = 1'($urandom_range(0, 1));
      mem_rd  = AW'($urandom_range(0, 3)); mem_wen = 1'($urandom_range(0, 1));
      wb_rd   = AW'($urandom_range(0, 3)); wb_wen  = 1'($urandom_range(0, 1));
      wb_data = $urandom;
      cyc("rand");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule